// File: doc/BRIEF.md
# Biphase and Differential Bit Decoder

This block turns a one-bit, already sliced and mixed-down radio data stream into decoded data bits. The input is sampled once per system clock, which runs at 4.332 MHz in the target system. At that rate one data bit spans 3648 clocks (1187.5 bit/s). The block keeps a free-running bit-phase counter with that period and pulls the counter toward the mid-bit transition that every biphase symbol carries. Over each bit it counts the high samples in the first and second half. A channel bit is decided from those two counts and then differentially decoded into a data bit.

Output is a stream of single bits, each marked by a one-clock strobe, together with a lock flag that reports whether mid-bit transitions keep landing inside the expected window. The output side has no ready signal and cannot be back-pressured. The consumer must take every strobe in the cycle it appears, and strobes are never closer together than half a bit period. Strobes and data are produced whether or not the lock flag is set. The consumer uses the lock flag to decide which bits to trust.

Top module: `bdd_decoder`

## Requirements
- R1: A synchronous reset clears the lock flag and the strobe, sets the bit-phase counter to position 0 (the first clock after reset is sample 0 of a bit), and clears the stored previous channel bit to 0.
- R2: With a steady, centred input, exactly one strobe is produced per BIT_CLKS clocks. It is one clock wide and appears in the clock after the counter's last sample of a bit. Counting from the first clock after reset, the strobe for bit j is seen after clock (j+1)*BIT_CLKS.
- R3: The channel bit is 1 when the number of high samples in the first half of the bit (counter positions 0 to BIT_CLKS/2-1) exceeds the number in the second half; otherwise it is 0. A high-then-low symbol therefore decodes as 1.
- R4: The data bit is the exclusive OR of the current channel bit and the previous channel bit.
- R5: A few inverted samples away from the mid-bit window do not change the decoded bit.
- R6: A transition seen up to TOL_CLKS clocks after the expected mid-bit position makes the counter hold for one clock. At most one correction is applied per bit.
- R7: A transition seen up to TOL_CLKS clocks before the expected mid-bit position makes the counter skip one position. At most one correction is applied per bit.
- R8: The lock flag rises at the end of the LOCK_HITS-th consecutive bit whose mid-bit transition fell inside the window (default 16).
- R9: The lock flag falls at the end of the LOCK_MISSES-th consecutive bit without such a transition (default 8).
- R10: A single bit with a valid mid-bit transition resets the run of misses, so the lock flag survives a gap shorter than LOCK_MISSES bits on each side of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (reference clock) |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Sliced baseband sample, synchronous to clk |
| data_o | output | 1 | Decoded data bit, valid when valid_o is high |
| valid_o | output | 1 | One-clock strobe per decoded bit |
| locked_o | output | 1 | Bit timing lock flag |

## Verification
The hardest state to reach from the ports is a bit-phase counter that sits a few clocks off the true symbol grid. Reset always starts the counter at position 0, so the bench starts the symbol stream a few samples late or a few samples early relative to reset. It then watches the strobe cycle settle onto the shifted grid, one correction per bit. Runs of symbol-free bits, with a single good symbol placed between them, drive the miss counter right up to its limit without reaching it.

// File: rtl/bdd_pkg.sv
package bdd_pkg;

  // Position of the current sample inside the bit period
  typedef struct packed {
    logic last;        // final sample of the bit
    logic first_half;  // sample lies in the first half-symbol
  } bdd_slot_t;

endpackage

// File: rtl/bdd_bit_timer.sv
module bdd_bit_timer
  import bdd_pkg::*;
#(
  parameter int BIT_CLKS = 3648,
  parameter int TOL_CLKS = 228,
  localparam int HALF = BIT_CLKS / 2,
  localparam int PH_W = $clog2(BIT_CLKS)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  output bdd_slot_t slot_o,
  output logic      mid_hit_o
);

  localparam logic [PH_W-1:0] P_LAST = PH_W'(BIT_CLKS - 1);
  localparam logic [PH_W-1:0] P_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0] P_LO   = PH_W'(HALF - TOL_CLKS);
  localparam logic [PH_W-1:0] P_HI   = PH_W'(HALF + TOL_CLKS);

  logic [PH_W-1:0] ph_q;
  logic            din_d;
  logic            corr_q;   // a correction was already applied this bit
  logic            edge_w;
  logic            early_w;
  logic            late_w;
  logic            centre_w;
  logic            last_w;

  assign edge_w   = din ^ din_d;
  assign centre_w = edge_w && (ph_q == P_HALF);
  assign last_w   = (ph_q == P_LAST);

  generate
    if (TOL_CLKS > 0) begin : g_window
      assign early_w = edge_w && (ph_q >= P_LO) && (ph_q < P_HALF);
      assign late_w  = edge_w && (ph_q > P_HALF) && (ph_q <= P_HI);
    end else begin : g_no_window
      assign early_w = 1'b0;
      assign late_w  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      din_d  <= 1'b0;
      corr_q <= 1'b0;
    end else begin
      din_d <= din;
      if (last_w) begin
        ph_q   <= '0;
        corr_q <= 1'b0;
      end else if (early_w && !corr_q) begin
        ph_q   <= ph_q + PH_W'(2);
        corr_q <= 1'b1;
      end else if (late_w && !corr_q) begin
        ph_q   <= ph_q;
        corr_q <= 1'b1;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign slot_o.last       = last_w;
  assign slot_o.first_half = (ph_q < P_HALF);
  assign mid_hit_o         = early_w || late_w || centre_w;

  AST_PH_WRAP: assert property (@(posedge clk) disable iff (rst)
    last_w |=> (ph_q == '0)); // R2

  AST_PH_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph_q <= P_LAST); // R2

  AST_RETARD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (late_w && !corr_q) |=> (ph_q == $past(ph_q))); // R6

  AST_ADVANCE_SKIP: assert property (@(posedge clk) disable iff (rst)
    (early_w && !corr_q) |=> (ph_q == $past(ph_q) + PH_W'(2))); // R7

  AST_ONE_CORR: assert property (@(posedge clk) disable iff (rst)
    (corr_q && !last_w) |=> corr_q); // R6

endmodule

// File: rtl/bdd_half_integrator.sv
module bdd_half_integrator
  import bdd_pkg::*;
#(
  parameter int BIT_CLKS = 3648,
  localparam int HALF  = BIT_CLKS / 2,
  localparam int CNT_W = $clog2(BIT_CLKS + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  bdd_slot_t slot_i,
  output logic      dec_vld_o,
  output logic      dec_bit_o
);

  logic [CNT_W-1:0] ones_a_q;
  logic [CNT_W-1:0] ones_b_q;
  logic [CNT_W:0]   b_total;

  // second-half total includes the sample arriving in the final clock
  assign b_total   = {1'b0, ones_b_q} + (CNT_W + 1)'(din);
  assign dec_bit_o = ({1'b0, ones_a_q} > b_total);
  assign dec_vld_o = slot_i.last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_a_q <= '0;
      ones_b_q <= '0;
    end else if (slot_i.last) begin
      ones_a_q <= '0;
      ones_b_q <= '0;
    end else if (slot_i.first_half) begin
      ones_a_q <= ones_a_q + CNT_W'(din);
    end else begin
      ones_b_q <= ones_b_q + CNT_W'(din);
    end
  end

  AST_HALF_A_MAX: assert property (@(posedge clk) disable iff (rst)
    ones_a_q <= CNT_W'(HALF)); // R3

  AST_HALF_B_MAX: assert property (@(posedge clk) disable iff (rst)
    ones_b_q <= CNT_W'(HALF + 1)); // R6

endmodule

// File: rtl/bdd_lock_monitor.sv
module bdd_lock_monitor #(
  parameter int LOCK_HITS   = 16,
  parameter int LOCK_MISSES = 8,
  localparam int HW = $clog2(LOCK_HITS + 1),
  localparam int MW = $clog2(LOCK_MISSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_end,
  input  logic mid_hit,
  output logic locked_o
);

  localparam logic [HW-1:0] H_TOP = HW'(LOCK_HITS - 1);
  localparam logic [MW-1:0] M_TOP = MW'(LOCK_MISSES - 1);

  logic          seen_q;
  logic [HW-1:0] hit_q;
  logic [MW-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      hit_q    <= '0;
      miss_q   <= '0;
      locked_o <= 1'b0;
    end else if (bit_end) begin
      seen_q <= 1'b0;
      if (seen_q) begin
        miss_q <= '0;
        if (hit_q == H_TOP) locked_o <= 1'b1;
        else                hit_q    <= hit_q + HW'(1);
      end else begin
        hit_q <= '0;
        if (miss_q == M_TOP) locked_o <= 1'b0;
        else                 miss_q   <= miss_q + MW'(1);
      end
    end else if (mid_hit) begin
      seen_q <= 1'b1;
    end
  end

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> ($past(hit_q) == H_TOP)); // R8

  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> ($past(miss_q) == M_TOP)); // R9

  AST_LOCK_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !bit_end |=> $stable(locked_o)); // R10

endmodule

// File: rtl/bdd_decoder.sv
module bdd_decoder
  import bdd_pkg::*;
#(
  parameter int BIT_CLKS    = 3648,
  parameter int TOL_CLKS    = 228,
  parameter int LOCK_HITS   = 16,
  parameter int LOCK_MISSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic data_o,
  output logic valid_o,
  output logic locked_o
);

  bdd_slot_t slot;
  logic      mid_hit;
  logic      dec_vld;
  logic      dec_bit;
  logic      prev_chan_q;

  bdd_bit_timer #(
    .BIT_CLKS (BIT_CLKS),
    .TOL_CLKS (TOL_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .slot_o    (slot),
    .mid_hit_o (mid_hit)
  );

  bdd_half_integrator #(
    .BIT_CLKS (BIT_CLKS)
  ) u_integ (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .slot_i    (slot),
    .dec_vld_o (dec_vld),
    .dec_bit_o (dec_bit)
  );

  bdd_lock_monitor #(
    .LOCK_HITS   (LOCK_HITS),
    .LOCK_MISSES (LOCK_MISSES)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .bit_end  (slot.last),
    .mid_hit  (mid_hit),
    .locked_o (locked_o)
  );

  // differential stage: a change of channel bit gives a 1
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_chan_q <= 1'b0;
      data_o      <= 1'b0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= dec_vld;
      if (dec_vld) begin
        data_o      <= dec_bit ^ prev_chan_q;
        prev_chan_q <= dec_bit;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R2

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !dec_vld |=> $stable(data_o)); // R4

endmodule

// File: tb/tb_bdd_decoder.sv
module tb_bdd_decoder;

  localparam int BIT  = 48;
  localparam int HALF = BIT / 2;
  localparam int TOL  = 8;
  localparam int MAXK = 64 * BIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic data_o, valid_o, locked_o;

  bdd_decoder #(.BIT_CLKS(BIT), .TOL_CLKS(TOL), .LOCK_HITS(16), .LOCK_MISSES(8)) dut (
    .clk(clk), .rst(rst), .din(din),
    .data_o(data_o), .valid_o(valid_o), .locked_o(locked_o)
  );

  always #10 clk = ~clk;

  int   nchk = 0, nfail = 0;
  int   pcnt = 0;
  int   ngot = 0;
  int   dbl = 0;
  bit   done = 0;
  logic vprev = 1'b0;
  logic got [0:127];
  int   gotk [0:127];
  logic lockh [0:MAXK-1];
  logic ch [0:63];
  logic en [0:63];
  int   nb_g = 0;
  bit   glitch = 0;

  always @(posedge clk) pcnt <= rst ? 0 : pcnt + 1;

  always @(negedge clk) begin
    if (pcnt < MAXK) lockh[pcnt] = locked_o;
    if (valid_o) begin
      if (vprev) dbl++;
      if (ngot < 128) begin
        got[ngot]  = data_o;
        gotk[ngot] = pcnt;
      end
      ngot++;
    end
    vprev = valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic smp(input int s);
    int b, p;
    logic v;
    if (s < 0) return 1'b0;
    b = s / BIT;
    p = s % BIT;
    if (b >= nb_g || !en[b]) return 1'b0;
    v = (p < HALF) ? ch[b] : ~ch[b];
    if (glitch && (p == 1 || p == BIT - 2)) v = ~v;
    return v;
  endfunction

  function automatic logic expd(input int j);
    return ch[j] ^ ((j > 0) ? ch[j-1] : 1'b0);
  endfunction

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < 64; i++) begin
      ch[i] = (((i * seed + i / 3) % 5) >= 2);
      en[i] = 1'b1;
    end
    nb_g = n;
  endtask

  task automatic play(input int nrun, input int off);
    rst = 1'b1;
    din = 1'b0;
    repeat (3) @(negedge clk);
    ngot = 0;
    rst = 1'b0;
    din = smp(-off);
    for (int k = 1; k <= nrun * BIT + 10; k++) begin
      @(negedge clk);
      din = smp(k - off);
    end
  endtask

  task automatic check_data(input int n, input string req);
    int bad = 0;
    for (int j = 0; j < n; j++)
      if (ngot <= j || got[j] !== expd(j)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // R2 R3 R4 R8: centred stream, decoding, strobe timing and lock rise
  task automatic t_aligned();
    fill(24, 7);
    ch[0]  = 1'b1;
    ch[23] = 1'b1;
    glitch = 0;
    play(24, 0);
    check_data(24, "R3/R4 decoded data");
    chk(gotk[23] == 24 * BIT, "R2 strobe cycle of bit 23", gotk[23], 24 * BIT);
    chk(lockh[16*BIT-1] === 1'b0, "R8 lock before 16th hit", lockh[16*BIT-1], 0);
    chk(lockh[16*BIT] === 1'b1, "R8 lock after 16th hit", lockh[16*BIT], 1);
  endtask

  // R1: reset clears lock and strobe
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(locked_o === 1'b0, "R1 lock cleared by reset", locked_o, 0);
    chk(valid_o === 1'b0, "R1 strobe cleared by reset", valid_o, 0);
  endtask

  // R1: previous channel bit cleared (last run ended with channel 1)
  task automatic t_prev_clear();
    fill(2, 3);
    ch[0] = 1'b1;
    play(2, 0);
    chk(ngot > 0 && got[0] === 1'b1, "R1 first data bit after reset", got[0], 1);
  endtask

  // R9: lock drops after 8 empty bits
  task automatic t_drop();
    fill(28, 5);
    for (int i = 20; i < 28; i++) en[i] = 1'b0;
    play(29, 0);
    chk(lockh[28*BIT-1] === 1'b1, "R9 lock before 8th miss", lockh[28*BIT-1], 1);
    chk(lockh[28*BIT] === 1'b0, "R9 lock after 8th miss", lockh[28*BIT], 0);
  endtask

  // R10: one good bit between two 7-bit gaps keeps the lock
  task automatic t_gap();
    int bad = 0;
    fill(35, 9);
    for (int i = 20; i < 27; i++) en[i] = 1'b0;
    for (int i = 28; i < 35; i++) en[i] = 1'b0;
    play(36, 0);
    for (int k = 16 * BIT; k <= 35 * BIT; k++) if (lockh[k] !== 1'b1) bad++;
    chk(bad == 0, "R10 lock held across gaps", bad, 0);
  endtask

  // R6: stream 5 samples late, counter retards onto it
  task automatic t_late();
    fill(24, 11);
    play(25, 5);
    chk(gotk[23] == 24 * BIT + 5, "R6 strobe after retard", gotk[23], 24 * BIT + 5);
    check_data(24, "R6 data while retarding");
  endtask

  // R7: stream 5 samples early, counter advances onto it
  task automatic t_early();
    fill(24, 13);
    play(25, -5);
    chk(gotk[23] == 24 * BIT - 5, "R7 strobe after advance", gotk[23], 24 * BIT - 5);
    check_data(24, "R7 data while advancing");
  endtask

  // R5: inverted samples near the bit edges
  task automatic t_noise();
    fill(24, 17);
    glitch = 1;
    play(24, 0);
    glitch = 0;
    check_data(24, "R5 data with inverted samples");
    chk(lockh[24*BIT] === 1'b1, "R5 lock kept with inverted samples", lockh[24*BIT], 1);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    t_aligned();
    t_reset();
    t_prev_clear();
    t_drop();
    t_gap();
    t_late();
    t_early();
    t_noise();
    chk(dbl == 0, "R2 strobe one clock wide", dbl, 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule